// File: doc/BRIEF.md
# Programmable Rate Generator Channel

This block is a single programmable counter channel that divides a qualified input clock by a reloadable 16-bit count. On each period it drives its output low for one count tick. Software first writes a control byte to the control port. The byte names the channel, the byte access order, the counting mode and the number format. Software then writes the count to the data port as two bytes, low byte first.

Counting begins only after the complete count has been written. After that, the channel reloads itself at the end of every period and runs with no further writes. A count written while the channel runs replaces the reload value without disturbing the period in progress. Writing a control byte again halts the channel until a fresh count arrives. Control bytes that ask for anything other than the rate-generator mode with a two-byte binary count leave the channel idle.

The counter advances only on clock edges where the count-enable input is high. This lets a slow count clock be expressed as an enable in the system clock domain.

Top module: `rate_timer_channel`

## Requirements
- R1: After reset the output is high and the channel is idle. Data-port writes made before any accepted control byte are ignored, and the output stays high however many count ticks follow.
- R2: A control-port write is taken only when its bits 7:6 equal the channel number (default 0). The byte arms the channel when bits 5:4 are 11 (low byte then high byte), bits 2:1 are 10 (mode field 010, or its alias 110) and bit 0 is 0 (binary), as with 0x34 or 0x3C. A control byte carrying another channel number changes nothing, not even a running count.
- R3: A control byte for this channel with any other access field, mode or number format stops the channel and leaves it idle. The output stays high and later data writes are ignored until an arming control byte is written.
- R4: After an arming control byte, data writes alternate between low byte and high byte, starting with the low byte. The low byte alone starts nothing. The count loaded is {second byte, first byte}.
- R5: On the first count tick after the high byte is written, the counter loads the count N. Counting ticks from 1 at that load tick, the output is low exactly on ticks that are multiples of N and high on all other ticks. Each low pulse lasts one tick.
- R6: A written count of 0 behaves as 65536, giving a period of 65536 ticks.
- R7: A full count written while the channel is running does not alter the current period. It is used from the next reload onward.
- R8: An accepted control byte stops counting and forces the output high. Neither changes until a full low-byte and high-byte count has been written and a new load tick has occurred.
- R9: On edges where the count enable is low, the counter and the output hold their values, including a low output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_ctrl | input | 1 | Port select: 1 = control port, 0 = data port |
| wr_data | input | 8 | Write data byte |
| wr_en | input | 1 | Write strobe, one write per clock with it high |
| cnt_en | input | 1 | Count-tick enable |
| tmr_out | output | 1 | Rate output, low for one tick per period |

## Verification
A wrong byte phase or a wrong staged low byte shows up as a wrong period. The error appears at the first low pulse, N ticks after the load tick. A counter that steps wrongly or reloads at the wrong value moves a pulse within one period. A missed halt or a missed arm shows on the output at the first tick after the control byte, or at the next expected pulse. The pulse positions are therefore compared on every tick against multiples of the period, and each idle window spans more than one period of the count last written.

// File: rtl/rate_timer_pkg.sv
// Shared types for the rate generator channel: control byte layout,
// access-order codes and the byte phase of the count loader.
package rate_timer_pkg;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LOW   = 2'b01,
        ACC_HIGH  = 2'b10,
        ACC_BOTH  = 2'b11
    } access_e;

    typedef struct packed {
        logic [1:0] chan;
        access_e    access;
        logic [2:0] mode;
        logic       bcd;
    } ctrl_byte_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } byte_phase_e;

endpackage

// File: rtl/rtc_ctrl_port.sv
// Control and data port decoder.
// Decodes control bytes addressed to this channel, arms the count loader
// only for the rate-generator / two-byte / binary setting, and assembles
// the count from a low byte followed by a high byte.
// Assumes at most one write per clock and a control byte in wr_data[7:0].
module rtc_ctrl_port
    import rate_timer_pkg::*;
#(
    parameter int BYTE_W       = 8,
    parameter int CHAN_ID      = 0,
    parameter bit ACCEPT_ALIAS = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_ctrl,
    input  logic [BYTE_W-1:0]     wr_data,
    input  logic                  wr_en,
    output logic                  halt,
    output logic                  load_stb,
    output logic [2*BYTE_W-1:0]   reload_val
);

    ctrl_byte_t          cbyte;
    logic                ctrl_hit;
    logic                data_wr;
    logic                mode_ok;
    logic                cfg_ok;
    logic                armed_q;
    byte_phase_e         phase_q;
    logic [BYTE_W-1:0]   low_q;

    assign cbyte    = ctrl_byte_t'(wr_data[7:0]);
    assign ctrl_hit = wr_en && sel_ctrl && (cbyte.chan == 2'(CHAN_ID));
    assign data_wr  = wr_en && !sel_ctrl;

    // Pick the accepted mode encodings: alias form or strict form
    generate
        if (ACCEPT_ALIAS) begin : g_alias_mode
            assign mode_ok = (cbyte.mode[1:0] == 2'b10);
        end else begin : g_strict_mode
            assign mode_ok = (cbyte.mode == 3'b010);
        end
    endgenerate

    assign cfg_ok   = mode_ok && (cbyte.access == ACC_BOTH) && !cbyte.bcd;
    assign halt     = ctrl_hit;
    assign load_stb = data_wr && armed_q && (phase_q == PH_HIGH);

    // Track the arm state, the byte phase and the staged count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q    <= 1'b0;
            phase_q    <= PH_LOW;
            low_q      <= '0;
            reload_val <= '0;
        end else if (ctrl_hit) begin
            armed_q <= cfg_ok;
            phase_q <= PH_LOW;
        end else if (data_wr && armed_q) begin
            if (phase_q == PH_LOW) begin
                low_q   <= wr_data;
                phase_q <= PH_HIGH;
            end else begin
                reload_val <= {wr_data, low_q};
                phase_q    <= PH_LOW;
            end
        end
    end

    // R3: data writes while disarmed leave the count untouched
    p_disarmed_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !armed_q) |=> $stable(reload_val));

    // R4: a low-byte write never changes the reload value
    p_low_byte_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && armed_q && phase_q == PH_LOW) |=> $stable(reload_val));

    // R2: a control byte for another channel leaves arm state and phase alone
    p_foreign_chan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_ctrl && cbyte.chan != 2'(CHAN_ID)) |=> ($stable(armed_q) && $stable(phase_q)));

endmodule

// File: rtl/rtc_reload_counter.sv
// Mode-2 reload down-counter.
// A start request arms a pending load. The next enabled tick copies the
// reload value into the counter, and later ticks count down. When the count
// reaches 1 the output goes low for one tick, then the counter reloads and
// the output returns high. A count of zero wraps, giving 2**CNT_W ticks.
// A halt request clears all activity and forces the output high.
module rtc_reload_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             halt,
    input  logic             start,
    input  logic [CNT_W-1:0] reload_val,
    output logic             out_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             running_q;
    logic             pend_q;

    // Next count value: reload at terminal count, otherwise step down
    always_comb begin
        cnt_next = (cnt_q == ONE) ? reload_val : cnt_q - ONE;
    end

    // Sequence the pending load, the countdown and the output pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
            pend_q    <= 1'b0;
            out_q     <= 1'b1;
        end else if (halt) begin
            running_q <= 1'b0;
            pend_q    <= 1'b0;
            out_q     <= 1'b1;
        end else begin
            if (tick && pend_q) begin
                cnt_q     <= reload_val;
                running_q <= 1'b1;
                pend_q    <= 1'b0;
                out_q     <= 1'b1;
            end else if (tick && running_q) begin
                cnt_q <= cnt_next;
                out_q <= (cnt_next != ONE);
            end
            if (start && !running_q && !pend_q) begin
                pend_q <= 1'b1;
            end
        end
    end

    // R8: an idle channel always drives its output high
    p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !running_q |-> out_q);

    // R8: a halt request leaves the channel stopped with its output high
    p_halt_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!running_q && out_q));

    // R5: a low output lasts a single tick when the period exceeds one
    p_single_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && tick && !out_q && reload_val != ONE) |=> out_q);

    // R5: away from terminal count the counter steps down by exactly one
    p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && tick && !halt && cnt_q != ONE) |=> (cnt_q == $past(cnt_q) - ONE));

    // R9: with no tick and no halt, counter and output hold
    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && !tick && !halt) |=> ($stable(cnt_q) && $stable(out_q)));

endmodule

// File: rtl/rate_timer_channel.sv
// Top of the rate generator channel: joins the port decoder to the reload
// counter. A control-port write halts the counter in the same edge, and a
// high-byte write requests a start in the same edge.
module rate_timer_channel #(
    parameter int BYTE_W       = 8,
    parameter int CHAN_ID      = 0,
    parameter bit ACCEPT_ALIAS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              cnt_en,
    output logic              tmr_out
);

    localparam int CNT_W = 2 * BYTE_W;

    logic             halt;
    logic             load_stb;
    logic [CNT_W-1:0] reload_val;

    rtc_ctrl_port #(
        .BYTE_W      (BYTE_W),
        .CHAN_ID     (CHAN_ID),
        .ACCEPT_ALIAS(ACCEPT_ALIAS)
    ) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_ctrl  (sel_ctrl),
        .wr_data   (wr_data),
        .wr_en     (wr_en),
        .halt      (halt),
        .load_stb  (load_stb),
        .reload_val(reload_val)
    );

    rtc_reload_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (cnt_en),
        .halt      (halt),
        .start     (load_stb),
        .reload_val(reload_val),
        .out_q     (tmr_out)
    );

endmodule

// File: tb/rate_timer_channel_bench.sv
// Directed bench for the rate generator channel. Inputs are driven on the
// falling edge; the output is sampled 1 ns after each rising edge.
module rate_timer_channel_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_ctrl = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_en = 1'b0;
    logic       cnt_en = 1'b0;
    logic       tmr_out;

    int checks = 0;
    int fails  = 0;
    int k      = 0;
    int per1   = 1;
    int per2   = 1;
    int edge_k = 1 << 30;

    always #5 clk = ~clk;

    rate_timer_channel u_rate_timer_channel (
        .clk(clk), .rst_n(rst_n), .sel_ctrl(sel_ctrl), .wr_data(wr_data),
        .wr_en(wr_en), .cnt_en(cnt_en), .tmr_out(tmr_out)
    );

    function automatic logic exp_out(int t);
        if (t <= edge_k) return (t % per1) != 0;
        return ((t - edge_k) % per2) != 0;
    endfunction

    task automatic check(string tag, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: tmr_out actual %0b expected %0b", tag, act, expv);
        end
    endtask

    task automatic wr(logic ctl, logic [7:0] d);
        @(negedge clk);
        sel_ctrl = ctl; wr_data = d; wr_en = 1'b1; cnt_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Restart tick numbering for a fresh count of period p
    task automatic new_period(int p);
        k = 0; per1 = p; edge_k = 1 << 30;
    endtask

    // Run n ticks comparing every sample with the pulse pattern
    task automatic run_ticks(int n, string tag);
        int bad = 0;
        logic first_act = 1'b0, first_exp = 1'b0;
        int first_k = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_en = 1'b1;
            @(posedge clk); #1; k++;
            if (tmr_out !== exp_out(k)) begin
                if (bad == 0) begin first_act = tmr_out; first_exp = exp_out(k); first_k = k; end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s: tick %0d tmr_out actual %0b expected %0b (%0d bad ticks)",
                     tag, first_k, first_act, first_exp, bad);
        end
    endtask

    // Run n ticks expecting the output to stay high
    task automatic run_idle(int n, string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_en = 1'b1;
            @(posedge clk); #1;
            if (tmr_out !== 1'b1) bad++;
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s: tmr_out actual 0 on %0d ticks expected 1", tag, bad);
        end
    endtask

    task automatic t_reset;
        @(posedge clk); #1;
        check("R1 reset level", tmr_out, 1'b1);
        wr(1'b0, 8'h05); wr(1'b0, 8'h00);
        run_idle(12, "R1 data before control");
    endtask

    task automatic t_basic;
        wr(1'b1, 8'h34); wr(1'b0, 8'h04);
        run_idle(9, "R4 low byte alone");
        wr(1'b0, 8'h00); new_period(4);
        run_ticks(13, "R5 R2 period 4");
    endtask

    task automatic t_order;
        wr(1'b1, 8'h34); wr(1'b0, 8'h03); wr(1'b0, 8'h01); new_period(259);
        run_ticks(600, "R4 count 0x0103");
    endtask

    task automatic t_pause;
        wr(1'b1, 8'h34); wr(1'b0, 8'h07); wr(1'b0, 8'h00); new_period(7);
        run_ticks(7, "R5 period 7");
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); cnt_en = 1'b0;
            @(posedge clk); #1;
            check("R9 hold low while paused", tmr_out, 1'b0);
        end
        run_ticks(15, "R9 resume after pause");
    endtask

    task automatic t_reload;
        wr(1'b1, 8'h34); wr(1'b0, 8'h05); wr(1'b0, 8'h00); new_period(5);
        run_ticks(7, "R7 before update");
        wr(1'b0, 8'h03); wr(1'b0, 8'h00);
        per2 = 3; edge_k = 10;
        run_ticks(12, "R7 update at next reload");
    endtask

    task automatic t_halt;
        wr(1'b1, 8'h34); wr(1'b0, 8'h06); wr(1'b0, 8'h00); new_period(6);
        run_ticks(8, "R8 running before halt");
        wr(1'b1, 8'h34);
        @(posedge clk); #1;
        check("R8 high right after control", tmr_out, 1'b1);
        run_idle(20, "R8 halted");
        wr(1'b0, 8'h02);
        run_idle(5, "R8 halted after low byte");
        wr(1'b0, 8'h00); new_period(2);
        run_ticks(9, "R8 restart period 2");
    endtask

    task automatic t_chan;
        wr(1'b1, 8'h34); wr(1'b0, 8'h04); wr(1'b0, 8'h00); new_period(4);
        run_ticks(5, "R2 before foreign byte");
        wr(1'b1, 8'h74);
        run_ticks(11, "R2 foreign channel ignored");
        wr(1'b1, 8'h3C); wr(1'b0, 8'h03); wr(1'b0, 8'h00); new_period(3);
        run_ticks(9, "R2 alias mode 110");
    endtask

    task automatic t_unsupported;
        wr(1'b1, 8'h36); wr(1'b0, 8'h04); wr(1'b0, 8'h00);
        run_idle(20, "R3 mode 3 idle");
        wr(1'b1, 8'h35); wr(1'b0, 8'h04); wr(1'b0, 8'h00);
        run_idle(20, "R3 bcd idle");
        wr(1'b1, 8'h14); wr(1'b0, 8'h04); wr(1'b0, 8'h00);
        run_idle(20, "R3 low-only access idle");
    endtask

    task automatic t_zero;
        wr(1'b1, 8'h34); wr(1'b0, 8'h00); wr(1'b0, 8'h00); new_period(65536);
        run_ticks(131073, "R6 count zero period 65536");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_order();
        t_pause();
        t_reload();
        t_halt();
        t_chan();
        t_unsupported();
        t_zero();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (185000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run actual hung expected complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule